// File: doc/BRIEF.md
# Secure-Aware Interrupt Set-Enable Register

This block holds one enable bit for each of a core's 32 private interrupts: the software-generated ones in the low half and the private peripheral ones in the high half. Software reaches it over a plain register bus that carries an address, a write strobe, write data, combinational read data and a flag for a secure access. Writing a one to a bit turns forwarding of that interrupt on. Writing a zero does nothing, so a bit can only be turned off again by reset. The stored bits go out as an enable vector to the logic that forwards interrupts to the CPU interface.

Each access is filtered bit by bit. An input mask gives every interrupt a security group, secure or non-secure. Two further inputs say whether affinity routing is on for secure interrupts and for non-secure interrupts. A global security-disable input collapses the two security states into one. A bit that the current access may not see reads as zero, and a write to it is dropped. The enable vector is also gated off for any interrupt whose group has affinity routing turned off.

Top module: `irq_set_enable_reg`

## Requirements
- R1: The register has 32 bits and bit i belongs to interrupt i. Bits 15:0 are the software-generated interrupts and bits 31:16 are the private peripheral interrupts, and every bit position, including 0 and 31, behaves in the same way.
- R2: A write (`bus_wr`=1 with `bus_addr`=`REG_ADDR`) that carries a 1 on an accessible bit sets that bit at the next rising clock edge.
- R3: A 0 in the write data never changes the stored bit.
- R4: Read data at `REG_ADDR` is combinational and equals the stored enables on the bits that the current access may see. A read after a write of 1 returns 1.
- R5: Every enable bit is 0 after reset.
- R6: A bit whose group has affinity routing off reads as 0 and ignores writes. `route_en_ns` governs bits with `grp_ns`=1 and `route_en_sec` governs bits with `grp_ns`=0.
- R7: When `sec_disable`=0 and `bus_secure`=0, bits with `grp_ns`=0 read as 0 and ignore writes. A secure access (`bus_secure`=1) may see bits of both groups.
- R8: When `sec_disable`=1, a non-secure access reads and sets secure-group bits just as it does non-secure ones.
- R9: `fwd_enable` equals the stored enables with every bit forced to 0 whose group has affinity routing off. It does not depend on the bus access.
- R10: An access at any address other than `REG_ADDR` leaves the stored bits unchanged and returns 0 read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Access address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | N_IRQ (32) | Write data, where a 1 sets a bit |
| bus_secure | input | 1 | 1 when the access is secure |
| bus_rdata | output | N_IRQ (32) | Masked read data |
| sec_disable | input | 1 | 1 merges the two security states into one |
| route_en_sec | input | 1 | Affinity routing on for secure-group interrupts |
| route_en_ns | input | 1 | Affinity routing on for non-secure-group interrupts |
| grp_ns | input | N_IRQ (32) | Per-interrupt group, where 1 is non-secure |
| fwd_enable | output | N_IRQ (32) | Enable vector to the forwarding logic |

## Verification
The assertions assume that the configuration inputs (`grp_ns`, the routing enables and `sec_disable`) hold steady around each rising edge, and that the address and strobe are valid levels while out of reset. The read-data checks sample combinational outputs at the edge, so they also assume that the bus inputs settle before that edge. The stimulus keeps within these limits by changing every input only on the falling edge and holding it there for a whole cycle. It also changes the configuration only between accesses, never in the middle of one.

// File: rtl/irq_sen_pkg.sv
package irq_sen_pkg;

   localparam int unsigned IRQ_MAX = 32;

   typedef enum logic {
      GRP_SECURE = 1'b0,
      GRP_NONSEC = 1'b1
   } irq_group_e;

   // A bit is visible when its group is routed and the access may see that group.
   function automatic logic bit_visible(input logic routed,
                                        input logic grp_is_ns,
                                        input logic acc_secure,
                                        input logic sec_dis);
      return routed & (sec_dis | acc_secure | grp_is_ns);
   endfunction

endpackage

// File: rtl/irq_sen_access_mask.sv
module irq_sen_access_mask
   import irq_sen_pkg::*;
#(
   parameter int unsigned N_IRQ = 32
) (
   input  logic [N_IRQ-1:0] grp_ns,
   input  logic             route_en_sec,
   input  logic             route_en_ns,
   input  logic             acc_secure,
   input  logic             sec_disable,
   output logic [N_IRQ-1:0] routed,
   output logic [N_IRQ-1:0] visible
);

   if (N_IRQ == 0 || N_IRQ > IRQ_MAX) begin : g_bad_width
      $error("irq_sen_access_mask: N_IRQ out of range");
   end

   for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
      irq_group_e grp;
      assign grp        = irq_group_e'(grp_ns[i]);
      assign routed[i]  = (grp == GRP_NONSEC) ? route_en_ns : route_en_sec;
      assign visible[i] = bit_visible(routed[i], grp_ns[i], acc_secure, sec_disable);
   end

endmodule

// File: rtl/irq_sen_enable_bits.sv
module irq_sen_enable_bits #(
   parameter int unsigned N_IRQ = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] set_req,
   output logic [N_IRQ-1:0] q
);

   if (N_IRQ == 0) begin : g_bad_width
      $error("irq_sen_enable_bits: N_IRQ must be nonzero");
   end

   for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q[i] <= 1'b0;
         else if (set_req[i]) q[i] <= 1'b1;
      end
   end

   // Set-only storage: a bit that was set stays set until reset (R3).
   assert_set_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q & $past(q)) == $past(q)));

   // A requested bit is set one edge later (R2).
   assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req != '0) |=> ((q & $past(set_req)) == $past(set_req)));

endmodule

// File: rtl/irq_set_enable_reg.sv
module irq_set_enable_reg #(
   parameter int unsigned N_IRQ     = 32,
   parameter int unsigned N_SGI     = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [N_IRQ-1:0]  bus_wdata,
   input  logic              bus_secure,
   output logic [N_IRQ-1:0]  bus_rdata,
   input  logic              sec_disable,
   input  logic              route_en_sec,
   input  logic              route_en_ns,
   input  logic [N_IRQ-1:0]  grp_ns,
   output logic [N_IRQ-1:0]  fwd_enable
);

   localparam int unsigned N_PPI = N_IRQ - N_SGI;

   if (N_SGI >= N_IRQ || N_PPI == 0) begin : g_bad_split
      $error("irq_set_enable_reg: SGI/PPI split leaves no PPI bits");
   end
   if (ADDR_W == 0) begin : g_bad_addr
      $error("irq_set_enable_reg: ADDR_W must be nonzero");
   end

   logic             addr_hit;
   logic             wr_hit;
   logic [N_IRQ-1:0] routed;
   logic [N_IRQ-1:0] visible;
   logic [N_IRQ-1:0] set_req;
   logic [N_IRQ-1:0] stored;

   assign addr_hit = (bus_addr == REG_ADDR);
   assign wr_hit   = addr_hit & bus_wr;

   irq_sen_access_mask #(.N_IRQ(N_IRQ)) u_mask (
      .grp_ns       (grp_ns),
      .route_en_sec (route_en_sec),
      .route_en_ns  (route_en_ns),
      .acc_secure   (bus_secure),
      .sec_disable  (sec_disable),
      .routed       (routed),
      .visible      (visible)
   );

   assign set_req = wr_hit ? (bus_wdata & visible) : '0;

   irq_sen_enable_bits #(.N_IRQ(N_IRQ)) u_bits (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_req),
      .q       (stored)
   );

   assign bus_rdata  = addr_hit ? (stored & visible) : '0;
   assign fwd_enable = stored & routed;

   // Bits whose group is not routed, derived straight from the ports.
   logic [N_IRQ-1:0] unrouted_chk;
   assign unrouted_chk = (grp_ns & {N_IRQ{~route_en_ns}}) | (~grp_ns & {N_IRQ{~route_en_sec}});

   assert_route_raz_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((bus_rdata & unrouted_chk) == '0));

   assert_ns_secure_raz_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_disable && !bus_secure) |-> ((bus_rdata & ~grp_ns) == '0));

   assert_fwd_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((fwd_enable & unrouted_chk) == '0));

   assert_miss_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != REG_ADDR) |-> (bus_rdata == '0));

   assert_miss_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != REG_ADDR) |=> $stable(stored));

   assert_ns_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !sec_disable && !bus_secure) |=>
         ((stored & ~$past(grp_ns)) == ($past(stored) & ~$past(grp_ns))));

endmodule

// File: tb/irq_set_enable_reg_test.sv
module irq_set_enable_reg_test;

   localparam logic [7:0] REG = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_secure = 1'b0;
   logic [31:0] bus_rdata;
   logic        sec_disable = 1'b0;
   logic        route_en_sec = 1'b1;
   logic        route_en_ns = 1'b1;
   logic [31:0] grp_ns = 32'hFFFF_0000;
   logic [31:0] fwd_enable;

   int checks = 0;
   int failures = 0;
   logic [31:0] model = '0;

   always #2 clk = ~clk;

   irq_set_enable_reg uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_rdata(bus_rdata),
      .sec_disable(sec_disable), .route_en_sec(route_en_sec),
      .route_en_ns(route_en_ns), .grp_ns(grp_ns), .fwd_enable(fwd_enable)
   );

   function automatic logic [31:0] m_routed();
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = grp_ns[i] ? route_en_ns : route_en_sec;
      return r;
   endfunction

   function automatic logic [31:0] m_visible();
      logic [31:0] v;
      logic [31:0] r;
      r = m_routed();
      for (int i = 0; i < 32; i++)
         v[i] = r[i] && (sec_disable || bus_secure || grp_ns[i]);
      return v;
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // One bus cycle: drive on the falling edge, compare against the model, then apply the write.
   task automatic step(string tag, logic [7:0] a, logic w, logic [31:0] d, logic sec,
                       logic sd, logic rs, logic rn, logic [31:0] g);
      logic [31:0] exp_rd;
      logic [31:0] vis;
      @(negedge clk);
      bus_addr = a; bus_wr = w; bus_wdata = d; bus_secure = sec;
      sec_disable = sd; route_en_sec = rs; route_en_ns = rn; grp_ns = g;
      #1;
      vis = m_visible();
      exp_rd = (a == REG) ? (model & vis) : '0;
      check(tag, "rdata", bus_rdata, exp_rd);
      check(tag, "fwd", fwd_enable, model & m_routed());
      @(posedge clk);
      if (w && a == REG) model = model | (d & vis);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      logic [31:0] g;
      g = 32'hFFFF_0000;
      repeat (3) @(posedge clk);
      #1;
      check("R5", "rdata_in_reset", bus_rdata, 32'h0);
      check("R5", "fwd_in_reset", fwd_enable, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      // R5: all bits clear after reset, secure read sees everything
      step("R5", REG, 0, '0, 1, 0, 1, 1, g);
      // R2 secure write sets bits in both groups; R4 read back
      step("R2", REG, 1, 32'h0003_00F0, 1, 0, 1, 1, g);
      step("R4", REG, 0, '0, 1, 0, 1, 1, g);
      // R3 zeros change nothing
      step("R3", REG, 1, 32'h0000_0000, 1, 0, 1, 1, g);
      step("R3", REG, 0, '0, 1, 0, 1, 1, g);
      // R7 non-secure write with security enabled: secure-group bits dropped
      step("R7", REG, 1, 32'h0F00_0F00, 0, 0, 1, 1, g);
      step("R7", REG, 0, '0, 0, 0, 1, 1, g);
      step("R7", REG, 0, '0, 1, 0, 1, 1, g);
      // R8 security disabled: non-secure access reaches secure-group bits
      step("R8", REG, 1, 32'h0000_F000, 0, 1, 1, 1, g);
      step("R8", REG, 0, '0, 0, 1, 1, 1, g);
      // R6/R9 non-secure routing off: RAZ/WI and forwarding gated
      step("R6", REG, 1, 32'h00F0_0000, 1, 0, 1, 0, g);
      step("R9", REG, 0, '0, 1, 0, 1, 0, g);
      step("R6", REG, 0, '0, 1, 0, 1, 1, g);
      // R6/R9 secure routing off
      step("R6", REG, 1, 32'h0000_000F, 1, 0, 0, 1, g);
      step("R9", REG, 0, '0, 1, 0, 0, 1, g);
      step("R6", REG, 0, '0, 1, 0, 1, 1, g);
      // R10 other address: ignored and reads zero
      step("R10", 8'h44, 1, 32'hFFFF_FFFF, 1, 1, 1, 1, g);
      step("R10", 8'h00, 0, '0, 1, 1, 1, 1, g);
      step("R10", REG, 0, '0, 1, 1, 1, 1, g);
      // R1 edge bits 0 and 31 with a different group map
      g = 32'h8000_0001;
      step("R1", REG, 1, 32'h8000_0001, 0, 0, 1, 1, g);
      step("R1", REG, 0, '0, 1, 0, 1, 1, g);
      step("R1", REG, 0, '0, 0, 0, 1, 1, g);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule